// File: doc/BRIEF.md
# Vectored interrupt controller with end-of-interrupt handshake

The controller collects up to 32 level-sensitive interrupt request lines and drives a single interrupt output towards a host processor. A 32-bit register slave lets the host enable and disable lines, look at the pending requests, fetch the vector of the line being served, raise a software request and acknowledge the current interrupt. A small table RAM holds one 32-bit vector word per line, and the host can read and write it freely.

Only one request is served at a time. When the controller is idle and enabled, it picks the lowest-numbered pending line and latches its index. It then raises the output and holds the choice until the host writes the end-of-interrupt register. After that write, the output drops for at least one cycle and the next pending line is taken. A line that is still high at that point is served again. The output is either a level, which may be inverted, or one pulse of programmable length per served interrupt.

The state machine has five states:
- `ST_IDLE` takes a request (*take*) and moves to `ST_LEVEL` in level mode or to `ST_PULSE` in pulse mode.
- `ST_PULSE` counts down (*expire*) into `ST_HOLD`.
- `ST_LEVEL`, `ST_PULSE` and `ST_HOLD` all leave on an end-of-interrupt write (*ack*) to `ST_GAP`.
- `ST_GAP` always returns to `ST_IDLE` (*rearm*).
- Clearing the global enable bit forces `ST_IDLE` from any state (*off*).

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the control word, the enable mask and the software request are zero, the state machine is idle and `irq_out` is low.
- R2: A write to byte offset 0x08 sets the enable bits for each 1 in the data, and a write to 0x0C clears them. Reading either offset returns the mask, so writing all ones to 0x0C disables every line.
- R3: A read of offset 0x04 returns the pending requests ANDed with the enable mask: line n appears in bit n and the software request in bit 0. A line change is visible two clocks after it is sampled, because of the two-flop synchroniser.
- R4: While control bit 0 (global enable) is 0, the output is inactive in the same cycle and the state machine returns to idle.
- R5: The lowest-numbered enabled pending line is served. A read of offset 0x10 returns the table word of the served line, and that choice stays fixed until end-of-interrupt, even if a lower line becomes pending.
- R6: In level mode (control bit 2 = 0), the output is active from selection until any write to offset 0x14. It is then inactive for at least one cycle before the next pending line is presented.
- R7: In pulse mode (control bit 2 = 1), each served interrupt gives one active pulse of N clocks, where N is the value in control bits 15:8 and a value of 0 gives 1 clock. The output then stays inactive until end-of-interrupt. N = 250 is supported.
- R8: Control bit 1 inverts the output, so the inactive level is high and the active level is low.
- R9: Table entry i is at byte offset 0x20 + 4*i and is fully readable and writable.
- R10: Writing offset 0x18 with data bit 0 = 1 raises a software request on the line 0 path. Data bit 0 = 0 has no effect. End-of-interrupt while line 0 is served clears the software request.
- R11: A line still asserted after end-of-interrupt is served again.
- R12: An end-of-interrupt write while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | LINES | Level interrupt requests, asynchronous |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_out | output | 1 | Interrupt output to the host |

## Verification
The bench targets several corner cases:
- A lower line that arrives while a higher one is being served: a design that re-arbitrates would switch the vector mid-service.
- A device line that is still high at end-of-interrupt: a design that drops it would lose the interrupt.
- Disabling the global enable mid-service: a leaky design would keep the output active.
- The exact length of the 250-clock pulse and of the zero-length pulse: an off-by-one counter would show one clock too many or too few.
- Draining a software request with end-of-interrupt writes: a software request that never clears would keep the raw status non-zero forever.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEVEL,
        ST_PULSE,
        ST_HOLD,
        ST_GAP
    } vic_state_e;

    localparam int W_CTRL   = 0;
    localparam int W_RAW    = 1;
    localparam int W_ENSET  = 2;
    localparam int W_ENCLR  = 3;
    localparam int W_VECT   = 4;
    localparam int W_ACK    = 5;
    localparam int W_SOFT   = 6;
    localparam int TBL_BASE = 8;

    localparam int C_ON   = 0;
    localparam int C_INV  = 1;
    localparam int C_EDGE = 2;
    localparam int C_LEN  = 8;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/vic_vtable.sv
module vic_vtable #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [31:0]   rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [31:0]   rdata_b
);
    logic [31:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl import vic_pkg::*; #(
    parameter int LINES = 32,
    parameter int LEN_W = 8,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_lines,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq_out
);
    localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int WORD_AW = AW - 2;

    vic_state_e state, nxt;

    logic [LINES-1:0] sync_q, en_mask, raw;
    logic             ctl_on, ctl_inv, ctl_edge;
    logic [LEN_W-1:0] ctl_len, pulse_cnt;
    logic             sw_pend;
    logic [IDX_W-1:0] served_idx, grant_idx, tbl_idx;
    logic             any_req, take, serving, irq_active;
    logic [31:0]      tbl_rd, vec_rd, rd_mux, ctrl_word;
    logic [WORD_AW-1:0] word;
    logic             wr_en, rd_en, tbl_hit, tbl_we, eoi_wr;
    logic             unused_ok;

    assign unused_ok = ^{reg_wdata, reg_addr};

    // bus decode
    assign word    = reg_addr[AW-1:2];
    assign wr_en   = reg_sel && reg_wr;
    assign rd_en   = reg_sel && !reg_wr;
    assign tbl_hit = (int'(word) >= TBL_BASE) && (int'(word) < TBL_BASE + LINES);
    assign tbl_idx = IDX_W'(int'(word) - TBL_BASE);
    assign tbl_we  = wr_en && tbl_hit;
    assign eoi_wr  = wr_en && (int'(word) == W_ACK);

    vic_sync #(.W(LINES)) u_sync (
        .clk (clk), .rst (rst), .d (irq_lines), .q (sync_q)
    );

    assign raw = (sync_q | LINES'(sw_pend)) & en_mask;

    vic_prio #(.W(LINES), .IW(IDX_W)) u_prio (
        .req (raw), .any (any_req), .idx (grant_idx)
    );

    vic_vtable #(.N(LINES), .IW(IDX_W)) u_tbl (
        .clk     (clk),
        .we      (tbl_we),
        .waddr   (tbl_idx),
        .wdata   (reg_wdata),
        .raddr_a (tbl_idx),
        .rdata_a (tbl_rd),
        .raddr_b (served_idx),
        .rdata_b (vec_rd)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_on   <= 1'b0;
            ctl_inv  <= 1'b0;
            ctl_edge <= 1'b0;
            ctl_len  <= '0;
            en_mask  <= '0;
        end else if (wr_en) begin
            if (int'(word) == W_CTRL) begin
                ctl_on   <= reg_wdata[C_ON];
                ctl_inv  <= reg_wdata[C_INV];
                ctl_edge <= reg_wdata[C_EDGE];
                ctl_len  <= reg_wdata[C_LEN +: LEN_W];
            end
            if (int'(word) == W_ENSET) en_mask <= en_mask | reg_wdata[LINES-1:0];
            if (int'(word) == W_ENCLR) en_mask <= en_mask & ~reg_wdata[LINES-1:0];
        end
    end

    assign serving = (state == ST_LEVEL) || (state == ST_PULSE) || (state == ST_HOLD);
    assign take    = (state == ST_IDLE) && ctl_on && any_req;

    // software request
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_pend <= 1'b0;
        end else if (wr_en && int'(word) == W_SOFT && reg_wdata[0]) begin
            sw_pend <= 1'b1;
        end else if (eoi_wr && ctl_on && serving && served_idx == '0) begin
            sw_pend <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!ctl_on) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (any_req) nxt = ctl_edge ? ST_PULSE : ST_LEVEL;
                ST_LEVEL: if (eoi_wr) nxt = ST_GAP;
                ST_PULSE: begin
                    if (eoi_wr)               nxt = ST_GAP;
                    else if (pulse_cnt == '0) nxt = ST_HOLD;
                end
                ST_HOLD:  if (eoi_wr) nxt = ST_GAP;
                ST_GAP:   nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // served index and pulse counter
    always_ff @(posedge clk) begin
        if (rst) begin
            served_idx <= '0;
            pulse_cnt  <= '0;
        end else if (take) begin
            served_idx <= grant_idx;
            pulse_cnt  <= (ctl_len == '0) ? '0 : ctl_len - LEN_W'(1);
        end else if (state == ST_PULSE && pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        irq_active = ctl_on && ((state == ST_LEVEL) || (state == ST_PULSE));
        irq_out    = irq_active ^ ctl_inv;
    end

    // read path
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[C_ON]          = ctl_on;
        ctrl_word[C_INV]         = ctl_inv;
        ctrl_word[C_EDGE]        = ctl_edge;
        ctrl_word[C_LEN +: LEN_W] = ctl_len;
        rd_mux = '0;
        if (tbl_hit)                          rd_mux = tbl_rd;
        else if (int'(word) == W_CTRL)        rd_mux = ctrl_word;
        else if (int'(word) == W_RAW)         rd_mux = 32'(raw);
        else if (int'(word) == W_ENSET ||
                 int'(word) == W_ENCLR)       rd_mux = 32'(en_mask);
        else if (int'(word) == W_VECT)        rd_mux = vec_rd;
    end

    always_ff @(posedge clk) begin
        if (rst)        reg_rdata <= '0;
        else if (rd_en) reg_rdata <= rd_mux;
    end

    // R4: global enable off forces idle
    a_r4_off_idle: assert property (@(posedge clk) disable iff (rst)
        !ctl_on |=> state == ST_IDLE);
    // R6: level output held until end-of-interrupt
    a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEVEL && ctl_on && !eoi_wr) |=> state == ST_LEVEL);
    // R5: served line fixed while serving
    a_r5_idx_stable: assert property (@(posedge clk) disable iff (rst)
        serving |=> $stable(served_idx));
    // R7: pulse continues while counter non-zero
    a_r7_pulse_run: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && ctl_on && !eoi_wr && pulse_cnt != '0) |=> state == ST_PULSE);
    // R12: end-of-interrupt while idle does not enter the gap state
    a_r12_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && eoi_wr) |=> state != ST_GAP);
endmodule

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ln = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vic_ctrl dut (
        .clk (clk), .rst (rst), .irq_lines (ln),
        .reg_sel (sel), .reg_wr (wr), .reg_addr (addr),
        .reg_wdata (wdata), .reg_rdata (rdata), .irq_out (irq_out)
    );

    // behavioural reference model
    logic [31:0] m_s1, m_s2, m_en, m_raw;
    logic [31:0] m_tbl [32];
    logic        m_on, m_inv, m_edge, m_sw, m_exp, m_eoi;
    int          m_len, m_ph, m_idx, m_left;

    function automatic int lowest(logic [31:0] v);
        int r = 0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    assign m_raw = (m_s2 | {31'b0, m_sw}) & m_en;
    assign m_eoi = sel && wr && addr == 8'h14;
    assign m_exp = (m_on && (m_ph == 1 || m_ph == 2)) ^ m_inv;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_en <= '0; m_on <= 0; m_inv <= 0;
            m_edge <= 0; m_len <= 0; m_sw <= 0; m_ph <= 0; m_idx <= 0; m_left <= 0;
        end else begin
            m_s1 <= ln;
            m_s2 <= m_s1;
            if (sel && wr) begin
                if (addr == 8'h00) begin
                    m_on <= wdata[0]; m_inv <= wdata[1]; m_edge <= wdata[2];
                    m_len <= int'(wdata[15:8]);
                end
                if (addr == 8'h08) m_en <= m_en | wdata;
                if (addr == 8'h0C) m_en <= m_en & ~wdata;
                if (addr >= 8'h20 && addr < 8'hA0) m_tbl[(addr - 8'h20) >> 2] <= wdata;
            end
            if (sel && wr && addr == 8'h18 && wdata[0]) m_sw <= 1'b1;
            else if (m_eoi && m_on && m_ph >= 1 && m_ph <= 3 && m_idx == 0) m_sw <= 1'b0;
            if (!m_on) m_ph <= 0;
            else case (m_ph)
                0: if (m_raw != 0) begin
                       m_idx  <= lowest(m_raw);
                       m_ph   <= m_edge ? 2 : 1;
                       m_left <= (m_len == 0) ? 1 : m_len;
                   end
                1: if (m_eoi) m_ph <= 4;
                2: if (m_eoi) m_ph <= 4;
                   else if (m_left == 1) m_ph <= 3;
                   else m_left <= m_left - 1;
                3: if (m_eoi) m_ph <= 4;
                default: m_ph <= 0;
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) chk("R6/R7/R8 per-cycle irq_out", {31'b0, irq_out}, {31'b0, m_exp});
    end

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(negedge clk); d = rdata; sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, eois;
        idle(5);
        rst = 0;
        idle(1);
        chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
        br(8'h00, d); chk("R1 control word", d, 32'h0);
        br(8'h08, d); chk("R1 enable mask", d, 32'h0);
        br(8'h04, d); chk("R1 raw status", d, 32'h0);

        for (int i = 0; i < 32; i++) bw(8'(8'h20 + 4 * i), 32'h5A00_0000 | (i << 8) | i);
        br(8'h20 + 8'd68, d); chk("R9 table entry 17", d, m_tbl[17]);
        bw(8'h9C, 32'hDEAD_BEEF);
        br(8'h9C, d); chk("R9 table entry 31 rewrite", d, 32'hDEAD_BEEF);

        bw(8'h08, 32'h8000_00F0); bw(8'h08, 32'h3);
        br(8'h08, d); chk("R2 enable set", d, 32'h8000_00F3);
        bw(8'h0C, 32'h20);
        br(8'h0C, d); chk("R2 enable clear", d, 32'h8000_00D3);

        ln = 32'h8000_00A0;
        idle(4);
        br(8'h04, d); chk("R3 raw masked by enable", d, 32'h8000_0080);
        chk("R4 output inactive while disabled", {31'b0, irq_out}, 32'h0);

        bw(8'h00, 32'h1);
        idle(3);
        chk("R6 output active in level mode", {31'b0, irq_out}, 32'h1);
        br(8'h10, d); chk("R5 vector of line 7", d, m_tbl[7]);
        ln[4] = 1'b1;
        idle(4);
        br(8'h10, d); chk("R5 vector latched despite lower line", d, m_tbl[7]);
        ln[7] = 1'b0;
        idle(4);
        bw(8'h14, 32'h0);
        chk("R6 output released after ack", {31'b0, irq_out}, 32'h0);
        idle(3);
        br(8'h10, d); chk("R5 next lowest line 4", d, m_tbl[4]);

        bw(8'h14, 32'h0);
        idle(3);
        chk("R11 re-served still-high line", {31'b0, irq_out}, 32'h1);
        br(8'h10, d); chk("R11 vector again line 4", d, m_tbl[4]);

        bw(8'h00, 32'h0);
        chk("R4 output drops at disable", {31'b0, irq_out}, 32'h0);
        idle(3);
        bw(8'h00, 32'h1);
        idle(3);
        br(8'h10, d); chk("R4 served again after re-enable", d, m_tbl[4]);

        ln[4] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(3);
        br(8'h10, d); chk("R5 line 31 served", d, m_tbl[31]);
        ln[31] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(3);
        br(8'h04, d); chk("R3 raw empty with disabled line high", d, 32'h0);

        bw(8'h14, 32'h0); idle(2);
        chk("R12 ack while idle keeps output low", {31'b0, irq_out}, 32'h0);
        ln[1] = 1'b1; idle(4);
        br(8'h10, d); chk("R12 later request served normally", d, m_tbl[1]);
        ln[1] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(2);

        bw(8'h00, 32'h3); idle(2);
        chk("R8 inverted idle level high", {31'b0, irq_out}, 32'h1);
        ln[0] = 1'b1; idle(4);
        chk("R8 inverted active level low", {31'b0, irq_out}, 32'h0);
        ln[0] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(2);
        bw(8'h00, 32'h1);

        bw(8'h18, 32'h0); idle(2);
        br(8'h04, d); chk("R10 zero write no request", d, 32'h0);
        bw(8'h18, 32'h1);
        br(8'h04, d); chk("R10 software request pending", d, 32'h1);
        br(8'h10, d); chk("R10 software served as line 0", d, m_tbl[0]);
        eois = 0;
        for (int k = 0; k < 8; k++) begin
            br(8'h04, d);
            if (d == 0) break;
            bw(8'h14, 32'h0); eois++; idle(2);
        end
        chk("R10 drained with one ack", eois, 1);
        chk("R10 output idle after drain", {31'b0, irq_out}, 32'h0);

        bw(8'h00, 32'h1 | 32'h4 | (32'd250 << 8));
        ln[6] = 1'b1;
        hi = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); if (irq_out) hi++;
        end
        chk("R7 pulse length 250", hi, 250);
        chk("R7 inactive awaiting ack", {31'b0, irq_out}, 32'h0);
        ln[6] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(3);
        bw(8'h00, 32'h5);
        ln[1] = 1'b1;
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); if (irq_out) hi++;
        end
        chk("R7 zero length gives one clock", hi, 1);
        ln[1] = 1'b0; idle(4); bw(8'h14, 32'h0); idle(3);

        bw(8'h0C, 32'hFFFF_FFFF);
        br(8'h08, d); chk("R2 all lines disabled", d, 32'h0);
        ln = 32'hFFFF_FFFF; idle(4);
        br(8'h04, d); chk("R2 raw empty when all disabled", d, 32'h0);
        chk("R2 no output when all disabled", {31'b0, irq_out}, 32'h0);
        ln = '0;
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule